// File: doc/BRIEF.md
# Procedure Command and Status Register Engine

This block implements a small configuration-space capability. Software uses it to start hardware procedures on a link and to poll their outcome. The capability is four dwords wide:

- a header dword with the capability identity;
- a status dword;
- a control dword;
- a read-only dword holding the physical link number.

Writing a procedure number into the control dword either answers the request locally or hands it to an external procedure executor. Abort, no-op, unsupported numbers, and a repeat of the once-only calibration are answered locally. The executor receives a one-cycle launch pulse together with the procedure number. It replies with a done pulse and a result code.

A control write that arrives while a procedure is still running cancels that procedure. The block sends an abort pulse to the executor and records the aborted code before the new request takes effect. One calibration procedure (number 5 by default) is allowed to succeed only once. After it has succeeded, later requests for it complete at once with success, and the executor is not launched.

Top module: `proc_ctl_engine`

## Requirements
- R1: Dword 0 reads {8'h00, CAP_LEN, CAP_NEXT, 8'h09}. Dword 3 reads {24'h0, LINK_NUM}. Both are read-only.
- R2: After reset:
  - the status dword (dword 1) reads 0;
  - the control dword (dword 2) reads 0;
  - no launch or abort pulse is driven;
  - the once-only flag is clear.
- R3: A control write of a number in 4..12 has these effects, when no procedure is running:
  - in the following cycle, exec_start_o is high for exactly one cycle, with exec_proc_o equal to the number;
  - status reads 32'h8000_0000 (bit 31 = in progress, bit 30 = complete, bits 3:0 = code);
  - the control dword reads back the number.
- R4: A done pulse from the executor while a procedure runs has these effects from the next cycle:
  - bit 31 is clear;
  - bit 30 is set;
  - bits 3:0 hold exec_code_i.
- R5: Writing 1 (NOP) completes in the next cycle with status 32'h4000_0000, and no launch is made.
- R6: Writing 2, 3 or 13..15 completes in the next cycle with status 32'h4000_0004 (code 4 = unsupported), and no launch is made.
- R7: Writing 0 while a procedure runs has these effects in the next cycle:
  - a one-cycle exec_abort_o is driven;
  - status reads 32'h4000_0003 (code 3 = aborted);
  - the control dword reads 0.
- R8: A control write of a number in 4..12 while a procedure runs proceeds in this order:
  - first cycle: exec_abort_o pulses, no launch is made, and status reads 32'h8000_0003;
  - second cycle: exec_start_o pulses with the new number.
  A locally answered number written while a procedure runs also pulses exec_abort_o and then reports its own result.
- R9: Procedure 5 is marked done only when it completes with code 0. From then on, a request for 5 completes in the next cycle with status 32'h4000_0000 and no launch. A failed run does not mark it, and a reset clears the mark.
- R10: A done pulse while no procedure runs, and writes to dwords 0, 1 and 3, leave the status and control dwords unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Dword index within the capability |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| exec_start_o | output | 1 | One-cycle launch pulse to the executor |
| exec_abort_o | output | 1 | One-cycle abort pulse to the executor |
| exec_proc_o | output | 4 | Number of the current procedure |
| exec_done_i | input | 1 | Executor completion pulse |
| exec_code_i | input | 4 | Executor result code, valid with exec_done_i |

## Verification
A wrong sequencer state shows on the status dword one cycle after the write or done pulse that caused it. Examples are a stale busy flag, a lost pending launch, or a set once-only mark. Such a fault appears either as in-progress and complete both reading wrong, or as a missing or extra start or abort pulse in that same cycle. The once-only mark is invisible until procedure 5 is requested again. For that reason the bench runs procedure 5 through failure, success, repeat and reset. A classification error shows directly as the wrong code, or as a launch for a number that should have been answered locally.

// File: rtl/proc_ctl_pkg.sv
`timescale 1ns/1ps
package proc_ctl_pkg;
  typedef enum logic [2:0] {
    CL_ABORT,
    CL_NOP,
    CL_UNSUP,
    CL_RUN,
    CL_SKIP
  } proc_cls_e;

  localparam logic [3:0] CODE_OK      = 4'd0;
  localparam logic [3:0] CODE_ABORTED = 4'd3;
  localparam logic [3:0] CODE_UNSUP   = 4'd4;

  localparam logic [1:0] DW_HDR  = 2'd0;
  localparam logic [1:0] DW_STAT = 2'd1;
  localparam logic [1:0] DW_CTRL = 2'd2;
  localparam logic [1:0] DW_LINK = 2'd3;

  localparam logic [7:0] CAP_ID = 8'h09;
endpackage

// File: rtl/proc_decode.sv
`timescale 1ns/1ps
module proc_decode
  import proc_ctl_pkg::*;
#(
  parameter int PROC_W    = 4,
  parameter int RUN_LO    = 4,
  parameter int RUN_HI    = 12,
  parameter int ONCE_PROC = 5
) (
  input  logic [PROC_W-1:0] num_i,
  input  logic              once_done_i,
  output proc_cls_e         cls_o
);
  always_comb begin
    if (num_i == PROC_W'(0))                                      cls_o = CL_ABORT;
    else if (num_i == PROC_W'(1))                                 cls_o = CL_NOP;
    else if (num_i < PROC_W'(RUN_LO) || num_i > PROC_W'(RUN_HI))  cls_o = CL_UNSUP;
    else if (num_i == PROC_W'(ONCE_PROC) && once_done_i)          cls_o = CL_SKIP;
    else                                                          cls_o = CL_RUN;
  end
endmodule

// File: rtl/proc_seq.sv
`timescale 1ns/1ps
module proc_seq
  import proc_ctl_pkg::*;
#(
  parameter int PROC_W    = 4,
  parameter int ONCE_PROC = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [PROC_W-1:0] ctrl_num_i,
  input  proc_cls_e         cls_i,
  input  logic              done_i,
  input  logic [3:0]        code_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [PROC_W-1:0] cur_o,
  output logic              inprog_o,
  output logic              cmpl_o,
  output logic [3:0]        code_o,
  output logic              once_done_o
);
  logic              busy_q, pend_q, start_q, abort_q, cmpl_q, once_q;
  logic [3:0]        code_q;
  logic [PROC_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      cmpl_q  <= 1'b0;
      once_q  <= 1'b0;
      code_q  <= CODE_OK;
      cur_q   <= '0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      if (ctrl_wr_i) begin
        // any write cancels a running executor
        abort_q <= busy_q;
        busy_q  <= 1'b0;
        pend_q  <= 1'b0;
        cur_q   <= ctrl_num_i;
        unique case (cls_i)
          CL_ABORT: begin cmpl_q <= 1'b1; code_q <= CODE_ABORTED; end
          CL_NOP,
          CL_SKIP:  begin cmpl_q <= 1'b1; code_q <= CODE_OK; end
          CL_UNSUP: begin cmpl_q <= 1'b1; code_q <= CODE_UNSUP; end
          default: begin
            cmpl_q <= 1'b0;
            if (busy_q) begin
              pend_q <= 1'b1;
              code_q <= CODE_ABORTED;
            end else begin
              start_q <= 1'b1;
              busy_q  <= 1'b1;
              code_q  <= CODE_OK;
            end
          end
        endcase
      end else if (pend_q) begin
        pend_q  <= 1'b0;
        start_q <= 1'b1;
        busy_q  <= 1'b1;
      end else if (busy_q && done_i) begin
        busy_q <= 1'b0;
        cmpl_q <= 1'b1;
        code_q <= code_i;
        if (cur_q == PROC_W'(ONCE_PROC) && code_i == CODE_OK) once_q <= 1'b1;
      end
    end
  end

  assign start_o     = start_q;
  assign abort_o     = abort_q;
  assign cur_o       = cur_q;
  assign inprog_o    = busy_q | pend_q;
  assign cmpl_o      = cmpl_q;
  assign code_o      = code_q;
  assign once_done_o = once_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);  // R3
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inprog_o && cmpl_q));  // R3
  AST_DONE_COMPLETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i && !ctrl_wr_i) |=> (cmpl_q && !inprog_o && code_q == $past(code_i)));  // R4
  AST_UNSUP_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && cls_i == CL_UNSUP) |=> (cmpl_q && code_q == CODE_UNSUP && !start_q));  // R6
  AST_ABORT_NOT_WITH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_q && start_q));  // R8
  AST_ABORT_HAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !busy_q) |=> !abort_q);  // R8
  AST_ONCE_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && cls_i == CL_SKIP) |=> (!start_q && cmpl_q && code_q == CODE_OK));  // R9
endmodule

// File: rtl/cap_regs.sv
`timescale 1ns/1ps
module cap_regs
  import proc_ctl_pkg::*;
#(
  parameter int         PROC_W   = 4,
  parameter logic [7:0] CAP_NEXT = 8'h00,
  parameter logic [7:0] CAP_LEN  = 8'h10,
  parameter logic [7:0] LINK_NUM = 8'd0
) (
  input  logic [1:0]        addr_i,
  input  logic              inprog_i,
  input  logic              cmpl_i,
  input  logic [3:0]        code_i,
  input  logic [PROC_W-1:0] cur_i,
  output logic [31:0]       rdata_o
);
  always_comb begin
    unique case (addr_i)
      DW_HDR:  rdata_o = {8'h00, CAP_LEN, CAP_NEXT, CAP_ID};
      DW_STAT: rdata_o = {inprog_i, cmpl_i, 26'h0, code_i};
      DW_CTRL: rdata_o = {{(32-PROC_W){1'b0}}, cur_i};
      default: rdata_o = {24'h0, LINK_NUM};
    endcase
  end
endmodule

// File: rtl/proc_ctl_engine.sv
`timescale 1ns/1ps
module proc_ctl_engine
  import proc_ctl_pkg::*;
#(
  parameter int         PROC_W    = 4,
  parameter int         RUN_LO    = 4,
  parameter int         RUN_HI    = 12,
  parameter int         ONCE_PROC = 5,
  parameter logic [7:0] CAP_NEXT  = 8'h00,
  parameter logic [7:0] CAP_LEN   = 8'h10,
  parameter logic [7:0] LINK_NUM  = 8'd4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              exec_start_o,
  output logic              exec_abort_o,
  output logic [PROC_W-1:0] exec_proc_o,
  input  logic              exec_done_i,
  input  logic [3:0]        exec_code_i
);
  logic              ctrl_wr, inprog, cmpl, once_done;
  logic [3:0]        code;
  logic [PROC_W-1:0] cur, num;
  proc_cls_e         cls;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == DW_CTRL);
  assign num     = reg_wdata_i[PROC_W-1:0];

  proc_decode #(.PROC_W(PROC_W), .RUN_LO(RUN_LO), .RUN_HI(RUN_HI), .ONCE_PROC(ONCE_PROC)) u_decode (
    .num_i(num), .once_done_i(once_done), .cls_o(cls)
  );

  proc_seq #(.PROC_W(PROC_W), .ONCE_PROC(ONCE_PROC)) u_seq (
    .clk_i, .rst_ni,
    .ctrl_wr_i(ctrl_wr), .ctrl_num_i(num), .cls_i(cls),
    .done_i(exec_done_i), .code_i(exec_code_i),
    .start_o(exec_start_o), .abort_o(exec_abort_o), .cur_o(cur),
    .inprog_o(inprog), .cmpl_o(cmpl), .code_o(code), .once_done_o(once_done)
  );

  cap_regs #(.PROC_W(PROC_W), .CAP_NEXT(CAP_NEXT), .CAP_LEN(CAP_LEN), .LINK_NUM(LINK_NUM)) u_regs (
    .addr_i(reg_addr_i), .inprog_i(inprog), .cmpl_i(cmpl), .code_i(code), .cur_i(cur),
    .rdata_o(reg_rdata_o)
  );

  assign exec_proc_o = cur;

  AST_HDR_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == DW_HDR) |-> (reg_rdata_o[7:0] == CAP_ID));  // R1
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!exec_start_o && !exec_abort_o));  // R2
endmodule

// File: tb/proc_ctl_engine_tb.sv
`timescale 1ns/1ps
module proc_ctl_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        st, ab;
  logic [3:0]  pr;
  logic        done = 1'b0;
  logic [3:0]  dcode = '0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          is_exec;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  proc_ctl_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .exec_start_o(st), .exec_abort_o(ab), .exec_proc_o(pr),
    .exec_done_i(done), .exec_code_i(dcode)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_exec ? {30'h0, st, ab} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s act=%h exp=%h", it.tag, it.is_exec ? "exec" : "rdata", act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [31:0] v, input string tag);
    reg_addr = a;
    q.push_back('{1'b0, v, tag});
  endtask

  task automatic exp_ex(input logic s, input logic b, input string tag);
    q.push_back('{1'b1, {30'h0, s, b}, tag});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic fin(input logic [3:0] c);
    done = 1'b1; dcode = c;
    tick();
    done = 1'b0;
  endtask

  task automatic chk_proc(input logic [3:0] e, input string tag);
    checks++;
    if (pr !== e) begin
      errors++;
      $display("FAIL %s proc act=%0d exp=%0d", tag, pr, e);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R2 reset state
    exp_rd(2'd1, 32'h0, "R2"); exp_ex(0, 0, "R2"); tick();
    exp_rd(2'd2, 32'h0, "R2"); tick();
    // R1 header and link
    exp_rd(2'd0, 32'h0010_0009, "R1"); tick();
    exp_rd(2'd3, 32'h0000_0004, "R1"); tick();
    // R5 NOP
    wr(2'd2, 1); exp_ex(0, 0, "R5"); exp_rd(2'd1, 32'h4000_0000, "R5"); tick();
    exp_rd(2'd2, 32'h1, "R5"); tick();
    // R6 unsupported
    wr(2'd2, 2); exp_ex(0, 0, "R6"); exp_rd(2'd1, 32'h4000_0004, "R6"); tick();
    wr(2'd2, 3); exp_ex(0, 0, "R6"); exp_rd(2'd1, 32'h4000_0004, "R6"); tick();
    wr(2'd2, 14); exp_ex(0, 0, "R6"); exp_rd(2'd1, 32'h4000_0004, "R6"); tick();
    // R3 launch, R4 completion
    wr(2'd2, 4); exp_ex(1, 0, "R3"); exp_rd(2'd1, 32'h8000_0000, "R3"); chk_proc(4, "R3"); tick();
    exp_ex(0, 0, "R3"); exp_rd(2'd2, 32'h4, "R3"); tick();
    fin(4'd1); exp_rd(2'd1, 32'h4000_0001, "R4"); tick();
    exp_rd(2'd2, 32'h4, "R4"); tick();
    // R7 abort via 0
    wr(2'd2, 6); tick();
    wr(2'd2, 0); exp_ex(0, 1, "R7"); exp_rd(2'd1, 32'h4000_0003, "R7"); tick();
    exp_ex(0, 0, "R7"); exp_rd(2'd2, 32'h0, "R7"); tick();
    // R8 overriding write
    wr(2'd2, 7); tick();
    wr(2'd2, 9); exp_ex(0, 1, "R8"); exp_rd(2'd1, 32'h8000_0003, "R8"); tick();
    exp_ex(1, 0, "R8"); chk_proc(9, "R8"); tick();
    exp_ex(0, 0, "R8"); tick();
    fin(4'd0); exp_rd(2'd1, 32'h4000_0000, "R8"); tick();
    // R8 local number overriding a run
    wr(2'd2, 8); tick();
    wr(2'd2, 1); exp_ex(0, 1, "R8"); exp_rd(2'd1, 32'h4000_0000, "R8"); tick();
    // R9 once-only
    wr(2'd2, 5); exp_ex(1, 0, "R9"); tick();
    fin(4'd2); exp_rd(2'd1, 32'h4000_0002, "R9"); tick();
    wr(2'd2, 5); exp_ex(1, 0, "R9"); tick();
    fin(4'd0); exp_rd(2'd1, 32'h4000_0000, "R9"); tick();
    wr(2'd2, 5); exp_ex(0, 0, "R9"); exp_rd(2'd1, 32'h4000_0000, "R9"); tick();
    exp_rd(2'd2, 32'h5, "R9"); tick();
    // R10 ignored stimulus
    fin(4'd2); exp_rd(2'd1, 32'h4000_0000, "R10"); tick();
    wr(2'd1, 32'hFFFF_FFFF); exp_rd(2'd1, 32'h4000_0000, "R10"); tick();
    wr(2'd3, 32'h0000_0007); exp_rd(2'd2, 32'h5, "R10"); tick();
    exp_rd(2'd3, 32'h0000_0004, "R10"); tick();
    wr(2'd0, 32'h1234_5678); exp_rd(2'd0, 32'h0010_0009, "R10"); tick();
    // R9 reset clears once flag
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    exp_rd(2'd1, 32'h0, "R2"); tick();
    wr(2'd2, 5); exp_ex(1, 0, "R9"); tick();
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule